// File: doc/BRIEF.md
# Data Rate Detection Controller

This block picks the clock multiplication factor of a multirate receiver. It counts edges on the serial data input inside fixed windows. Each window is two recovered-clock periods long. Whenever one window holds more than two data transitions, the recovered clock is slower than the data. The block then doubles the factor and sends a one-cycle retrigger pulse, which tells the phase-alignment loop to return to its mid-point and align again.

Everything runs on a sampling clock that is faster than the data. The recovered-clock period at factor 1 is the parameter `RCLK_DIV`, counted in sampling cycles. At factor 2^k that period is `RCLK_DIV >> k`. Detection waits for the lock indicator. After each change of factor, a programmable number of settling windows is skipped before decisions resume. The factor rises one step at a time until the transition count per window is two or less. It then holds.

Top module: `rate_detect_ctrl`

## Requirements
- R1: While rst_ni is low, rate_o is 0 (factor 1) and retrig_o is 0.
- R2: While lock_i is low, rate_o does not change, retrig_o stays 0, and the window and transition counts are cleared.
- R3: data_i passes through a two-flop synchronizer. A change of data_i set up before clock edge k is counted at edge k+2.
- R4: With lock_i high, windows run back to back. Each window lasts (2*RCLK_DIV) >> rate_o sampling cycles. The first decision falls on the 2*RCLK_DIV-th edge after lock_i goes high at factor 1.
- R5: If more than 2 transitions are counted in a window, rate_o increases by 1 at that window's last edge. The only exceptions are the settling period (R7) and saturation (R8).
- R6: retrig_o is high for exactly the one cycle after each edge at which rate_o changes, and at no other time.
- R7: After each change of factor, the next SETTLE_WIN windows make no decision. With defaults (RCLK_DIV=32, SETTLE_WIN=2) and constant over-threshold data, the first two increments are 96 cycles apart.
- R8: rate_o saturates at 4. Over-threshold windows at code 4 produce no retrigger.
- R9: A window with 2 or fewer transitions leaves rate_o unchanged. For example, data toggling every (RCLK_DIV >> k) cycles settles at code k.
- R10: rate_o is a 3-bit log2 code: 0, 1, 2, 3 and 4 stand for factors 1, 2, 4, 8 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Lock indicator of the multiplying loop; enables detection |
| data_i | input | 1 | Serial data, asynchronous |
| rate_o | output | 3 | Multiplication factor as log2 code |
| retrig_o | output | 1 | One-cycle request to re-centre phase alignment |

## Verification
A data change reaches the transition count two edges later, through the synchronizer. A decision lands on the window's last edge. rate_o and retrig_o are registered at that same edge, so both show the update one cycle after the deciding edge. The bench drives inputs just after each falling edge and steps a behavioural model once per rising edge. It compares both outputs at the next falling edge, so every result is sampled in the cycle it is due. Directed cases also pin absolute timing: a transition placed one cycle too late for a window, the first decision edge, and the 96-cycle gap between increments caused by settling.

// File: rtl/rd_pkg.sv
package rd_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] rate_code_t;
  localparam rate_code_t MAX_CODE = 3'd4;
endpackage

// File: rtl/rd_sync.sv
module rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;

  // R3
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (prev_q == $past(sync_q[STAGES-1])));
endmodule

// File: rtl/rd_window.sv
module rd_window
  import rd_pkg::*;
#(
  parameter int RCLK_DIV = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  rate_code_t code_i,
  input  logic       edge_i,
  output logic       win_end_o,
  output logic       over_o
);
  localparam int BASE_LEN = 2 * RCLK_DIV;
  localparam int CNT_W    = $clog2(BASE_LEN) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win_last;
  logic [1:0]       tc_q;
  logic [2:0]       tc_sum;
  logic             win_start;

  assign win_last  = CNT_W'(BASE_LEN >> code_i) - CNT_W'(1);
  assign win_start = en_i && (cnt_q == '0);
  assign win_end_o = en_i && (cnt_q == win_last);
  assign tc_sum    = {1'b0, tc_q} + {2'b00, edge_i};
  assign over_o    = tc_sum > 3'd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= '0;
    end else if (!en_i || win_end_o) begin
      cnt_q <= '0;
      tc_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      tc_q  <= (tc_sum > 3'd3) ? 2'd3 : tc_sum[1:0];
    end
  end

  // R4
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BASE_LEN - 1));
  // R2
  lock_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && tc_q == '0));
  // R4
  win_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_o && !win_start) |=> (cnt_q == '0));
endmodule

// File: rtl/rd_factor.sv
module rd_factor
  import rd_pkg::*;
#(
  parameter int SETTLE_WIN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       win_end_i,
  input  logic       over_i,
  output rate_code_t code_o,
  output logic       retrig_o
);
  localparam int SET_W = $clog2(SETTLE_WIN + 2);

  rate_code_t       code_q;
  logic             retrig_q;
  logic [SET_W-1:0] settle_q;
  logic             bump;

  assign bump = win_end_i && (settle_q == '0) && over_i && (code_q < MAX_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      retrig_q <= 1'b0;
      settle_q <= '0;
    end else begin
      retrig_q <= bump;
      if (bump) begin
        code_q   <= code_q + 3'd1;
        settle_q <= SET_W'(SETTLE_WIN);
      end else if (win_end_i && settle_q != '0) begin
        settle_q <= settle_q - SET_W'(1);
      end
    end
  end

  assign code_o   = code_q;
  assign retrig_o = retrig_q;

  // R8
  code_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= MAX_CODE);
  // R5
  code_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> (code_q == $past(code_q) + 3'd1));
  // R7
  settle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settle_q != '0) |=> !retrig_q);
endmodule

// File: rtl/rate_detect_ctrl.sv
module rate_detect_ctrl
  import rd_pkg::*;
#(
  parameter int RCLK_DIV   = 32,
  parameter int SETTLE_WIN = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lock_i,
  input  logic       data_i,
  output logic [2:0] rate_o,
  output logic       retrig_o
);
  logic       data_edge;
  logic       win_end;
  logic       over;
  rate_code_t code;

  rd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (data_i),
    .edge_o(data_edge)
  );

  rd_window #(.RCLK_DIV(RCLK_DIV)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (lock_i),
    .code_i   (code),
    .edge_i   (data_edge),
    .win_end_o(win_end),
    .over_o   (over)
  );

  rd_factor #(.SETTLE_WIN(SETTLE_WIN)) u_factor (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_end_i(win_end),
    .over_i   (over),
    .code_o   (code),
    .retrig_o (retrig_o)
  );

  assign rate_o = code;

  // R6
  retrig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrig_o |=> !retrig_o);
  // R6
  retrig_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrig_o |-> (rate_o != $past(rate_o)));
  // R2
  lock_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> (!retrig_o && $stable(rate_o)));
endmodule

// File: tb/rate_detect_ctrl_bench.sv
module rate_detect_ctrl_bench;
  localparam int RCLK_DIV   = 32;
  localparam int SETTLE_WIN = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lock_i = 1'b0;
  logic       data_i = 1'b0;
  logic [2:0] rate_o;
  logic       retrig_o;

  always #4 clk = ~clk;

  rate_detect_ctrl #(.RCLK_DIV(RCLK_DIV), .SETTLE_WIN(SETTLE_WIN)) u_rate_detect_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .lock_i(lock_i), .data_i(data_i),
    .rate_o(rate_o), .retrig_o(retrig_o)
  );

  int checks = 0, fails = 0;
  int n_retrig = 0, cyc = 0;
  int retrig_at[$];
  bit done = 0;

  // behavioural reference state
  bit m_hist[$];
  int m_pos, m_tc, m_code, m_retrig, m_settle;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void m_reset();
    m_hist = '{0, 0, 0};
    m_pos = 0; m_tc = 0; m_code = 0; m_retrig = 0; m_settle = 0;
  endfunction

  // one rising edge of the reference
  function automatic void m_step(bit d, bit lk);
    int len, tr, total;
    tr = (m_hist[1] != m_hist[2]) ? 1 : 0;   // synchronized sample vs previous
    m_hist.push_front(d);
    void'(m_hist.pop_back());
    m_retrig = 0;
    if (!lk) begin
      m_pos = 0; m_tc = 0;
    end else begin
      len = (2 * RCLK_DIV) / (1 << m_code);
      total = m_tc + tr;
      if (m_pos == len - 1) begin
        if (m_settle > 0) m_settle--;
        else if (total > 2 && m_code < 4) begin
          m_code++; m_retrig = 1; m_settle = SETTLE_WIN;
        end
        m_pos = 0; m_tc = 0;
      end else begin
        m_pos++; m_tc = total;
      end
    end
  endfunction

  task automatic cycle(bit d, bit lk);
    data_i = d; lock_i = lk;
    m_step(d, lk);
    @(negedge clk);
    cyc++;
    chk(rate_o == 3'(m_code), "R4/R5/R9 rate vs model", rate_o, m_code);
    chk(retrig_o == m_retrig, "R6 retrig vs model", retrig_o, m_retrig);
    if (retrig_o) begin n_retrig++; retrig_at.push_back(cyc); end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; data_i = 1'b0; lock_i = 1'b0;
    m_reset();
    repeat (3) @(negedge clk);
    chk(rate_o == 3'd0, "R1 rate at reset", rate_o, 0);
    chk(retrig_o == 1'b0, "R1 retrig at reset", retrig_o, 0);
    rst_ni = 1'b1;
    n_retrig = 0; cyc = 0; retrig_at.delete();
  endtask

  // per = toggle period in sampling cycles, 0 = random data
  task automatic run(int n, bit lk, int per);
    bit d;
    d = data_i;
    for (int i = 0; i < n; i++) begin
      if (per == 0) d = 1'($urandom);
      else if (i % per == 0) d = ~d;
      cycle(d, lk);
    end
  endtask

  task automatic place(int last_at);
    bit d;
    d = 1'b0;
    for (int k = 1; k <= 200; k++) begin
      if (k == 10 || k == 20 || k == last_at) d = ~d;
      cycle(d, 1'b1);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: fast data, lock low
    run(500, 1'b0, 1);
    chk(rate_o == 3'd0, "R2 no change without lock", rate_o, 0);
    chk(n_retrig == 0, "R2 no retrig without lock", n_retrig, 0);
    // R9: toggle every 4 -> code 3 (factor 8, R10)
    run(3000, 1'b1, 4);
    chk(rate_o == 3'd3, "R9 settles at code 3", rate_o, 3);
    chk(n_retrig == 3, "R6 one retrig per step", n_retrig, 3);
    run(2000, 1'b1, 2);
    chk(rate_o == 3'd4, "R10 code 4 for factor 16", rate_o, 4);
    // R8: faster still, saturate
    run(2000, 1'b1, 1);
    chk(rate_o == 3'd4, "R8 saturated", rate_o, 4);
    chk(n_retrig == 4, "R8 no retrig at max", n_retrig, 4);

    do_reset();
    run(1500, 1'b1, 16);
    chk(rate_o == 3'd1, "R9 settles at code 1", rate_o, 1);

    // R4 and R7 timing
    do_reset();
    run(400, 1'b1, 1);
    chk(retrig_at.size() >= 2, "R7 two increments seen", retrig_at.size(), 2);
    if (retrig_at.size() >= 2) begin
      chk(retrig_at[0] == 2 * RCLK_DIV, "R4 first decision edge", retrig_at[0], 2 * RCLK_DIV);
      chk(retrig_at[1] - retrig_at[0] == 96, "R7 settle gap", retrig_at[1] - retrig_at[0], 96);
    end

    // R3: third transition just in time / one cycle late
    do_reset();
    place(62);
    chk(rate_o == 3'd1, "R3 transition counted at k+2", rate_o, 1);
    do_reset();
    place(63);
    chk(rate_o == 3'd0, "R3 late transition in next window", rate_o, 0);

    // random data with lock dropouts
    do_reset();
    for (int j = 0; j < 8; j++) run(500, (j % 3) != 2, 0);
    chk(rate_o <= 3'd4, "R8 code bound under random data", rate_o, 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule